// File: doc/BRIEF.md
# SMBus Configuration-Register Slave

This block is the two-wire serial slave that stands in front of the small configuration-register bank of a clock synthesizer. It watches an SCLK input that is already synchronised to the system clock and the wired-AND SDATA line. It recognises its own device address and decodes a command byte. It then performs one of four transfers against the bank: single-byte write, single-byte read, counted block write or counted block read. SDATA is only ever pulled low, through an output enable. The pull-up and the pad sit outside the block.

The command byte's top bit picks the kind of access. When it is set, the low seven bits are a register offset for a single-byte access. When it is clear, the transfer is a block transfer that always starts at offset 0. A block write carries a byte count before its data. A block read starts with a repeated start and the read address, and the slave answers with a byte count equal to the number of implemented registers. Register data then follows from offset 0 upward. Reset values live in the bank, so software never needs this interface.

Writes leave the block on a valid/ready port. `reg_wr_valid` rises once for each data byte that lands inside the implemented range. It stays high, with `reg_wr_addr` and `reg_wr_data` held stable, until the bank raises `reg_wr_ready`. The bank must take each item within about nine SCLK periods, before the next data byte completes, or the pending item is replaced. Reads use a plain combinational port: the block presents `reg_rd_addr`, and the bank returns `reg_rd_data` well before the next SCLK falling edge.

Top module: `smb_cfg_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal the parameter DEV_ADDR (default 7'h69, so D2h for a write and D3h for a read) by pulling SDATA low during the ninth clock.
- R2: An address byte with any other upper seven bits is not acknowledged. All later bytes are then neither acknowledged nor acted on until the next start condition.
- R3: A command byte with bit 7 = 1 selects single-byte access, with bits 6:0 as the register offset. Each following data byte of a write is written to that offset, and the offset then increments.
- R4: A command byte with bit 7 = 0 selects a block write. The next byte is a count, and the data bytes after it go to offsets 0, 1, 2 and so on. The slave acknowledges every byte.
- R5: A block read (command 00h, repeated start, read address) first returns the byte count NUM_REGS, then registers from offset 0 upward for as long as the master acknowledges. Positions past the last register return FFh.
- R6: A single-byte read (command 8xh, repeated start, read address) returns the register at the offset. An offset of NUM_REGS or above returns FFh.
- R7: Every byte is shifted most significant bit first in both directions.
- R8: A stop after any complete data byte ends the transfer with every complete byte already written. Bits of a partial byte before the stop are discarded.
- R9: After the master answers a transmitted byte with NACK, the slave releases SDATA and drives nothing until the next start or stop.
- R10: Write data bytes whose offset is NUM_REGS or above are acknowledged but produce no write.
- R11: A start condition seen in the middle of a byte abandons that byte and begins a new address phase.
- R12: `reg_wr_valid` is low after reset. Once it is high, it stays high with address and data unchanged until `reg_wr_ready` is seen high.
- R13: `sda_oe` is low after reset and changes only while SCLK is low, except that it may fall while SCLK is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCLK, already synchronised to clk |
| sda_i | input | 1 | SDATA line level, synchronised |
| sda_oe | output | 1 | 1 pulls SDATA low |
| reg_wr_valid | output | 1 | Write item pending |
| reg_wr_ready | input | 1 | Bank accepts the pending write |
| reg_wr_addr | output | AW | Register offset of the write, AW = clog2(NUM_REGS) |
| reg_wr_data | output | 8 | Write data |
| reg_rd_addr | output | AW | Register offset presented for reading |
| reg_rd_data | input | 8 | Register contents at reg_rd_addr |

## Verification
The transfers are driven with distinct patterns, and each one separates a different decision. A single-byte write followed by a read-back at the same offset shows that the offset field and the bit order are honoured. A block write stopped in the middle of a byte shows which bytes are committed. A write that runs past the last register shows that acknowledge and commit are independent. A block read that continues past the register count shows where the count byte, the data and the FFh filler each come from. A foreign address followed by bytes, a read that ends in NACK, and a start placed inside a byte each check that the slave stays silent or starts over. A bank that stalls `reg_wr_ready` checks that write items are held.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK_SET, ST_ACK, ST_TX, ST_MACK, ST_LOAD, ST_IGNORE
  } smb_state_e;

  typedef enum logic [1:0] {
    BK_ADDR, BK_CMD, BK_CNT, BK_DATA
  } smb_byte_kind_e;
endpackage

// File: rtl/smb_line_mon.sv
module smb_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic cond_start,
  output logic cond_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise   = scl_i & ~scl_q;
  assign scl_fall   = ~scl_i & scl_q;
  // data edges while the clock stays high are bus conditions
  assign cond_start = scl_i & scl_q & sda_q & ~sda_i;
  assign cond_stop  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/smb_wr_hold.sv
module smb_wr_hold #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [7:0]    push_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [7:0]    out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (push) begin
      out_valid <= 1'b1;
      out_addr  <= push_addr;
      out_data  <= push_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/smb_tx_sel.sv
module smb_tx_sel #(
  parameter int NUM_REGS = 8
) (
  input  logic       send_count,
  input  logic [7:0] ptr,
  input  logic [7:0] rd_data,
  output logic [7:0] tx_byte
);
  localparam logic [7:0] NREG8 = 8'(NUM_REGS);

  always_comb begin
    if (send_count)        tx_byte = NREG8;
    else if (ptr < NREG8)  tx_byte = rd_data;
    else                   tx_byte = 8'hFF;
  end
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter int          NUM_REGS = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  localparam int         AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          reg_wr_valid,
  input  logic          reg_wr_ready,
  output logic [AW-1:0] reg_wr_addr,
  output logic [7:0]    reg_wr_data,
  output logic [AW-1:0] reg_rd_addr,
  input  logic [7:0]    reg_rd_data
);
  import smb_pkg::*;

  localparam logic [7:0] NREG8 = 8'(NUM_REGS);

  logic scl_rise, scl_fall, cond_start, cond_stop;

  smb_state_e     state;
  smb_byte_kind_e kind;
  logic [3:0]     bit_cnt;
  logic [6:0]     shreg;
  logic [6:0]     tx_q;
  logic [7:0]     ptr;
  logic [6:0]     cmd_off;
  logic           blk_mode, have_cmd, send_count, ack_en, go_tx, oe_q;
  logic           push;
  logic [AW-1:0]  push_addr;
  logic [7:0]     push_data;
  logic [7:0]     byte_in, tx_byte, ptr_nxt;
  logic           in_range;

  smb_line_mon u_line (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .cond_start(cond_start), .cond_stop(cond_stop)
  );

  smb_tx_sel #(.NUM_REGS(NUM_REGS)) u_txsel (
    .send_count(send_count), .ptr(ptr), .rd_data(reg_rd_data), .tx_byte(tx_byte)
  );

  smb_wr_hold #(.AW(AW)) u_hold (
    .clk(clk), .rst_n(rst_n), .push(push), .push_addr(push_addr),
    .push_data(push_data), .out_valid(reg_wr_valid), .out_ready(reg_wr_ready),
    .out_addr(reg_wr_addr), .out_data(reg_wr_data)
  );

  assign byte_in     = {shreg, sda_i};
  assign in_range    = ptr < NREG8;
  assign ptr_nxt     = (ptr == 8'hFF) ? ptr : ptr + 8'd1;
  assign reg_rd_addr = ptr[AW-1:0];
  assign sda_oe      = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      kind       <= BK_ADDR;
      bit_cnt    <= '0;
      shreg      <= '0;
      tx_q       <= '0;
      ptr        <= '0;
      cmd_off    <= '0;
      blk_mode   <= 1'b1;
      have_cmd   <= 1'b0;
      send_count <= 1'b0;
      ack_en     <= 1'b0;
      go_tx      <= 1'b0;
      oe_q       <= 1'b0;
      push       <= 1'b0;
      push_addr  <= '0;
      push_data  <= '0;
    end else begin
      push <= 1'b0;
      if (cond_stop) begin
        state    <= ST_IDLE;
        oe_q     <= 1'b0;
        have_cmd <= 1'b0;
      end else if (cond_start) begin
        state   <= ST_RX;
        kind    <= BK_ADDR;
        bit_cnt <= '0;
        oe_q    <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: if (scl_rise) begin
            shreg <= {shreg[5:0], sda_i};
            if (bit_cnt == 4'd7) begin
              bit_cnt <= '0;
              state   <= ST_ACK_SET;
              ack_en  <= 1'b1;
              go_tx   <= 1'b0;
              unique case (kind)
                BK_ADDR: begin
                  if (byte_in[7:1] != DEV_ADDR) begin
                    ack_en <= 1'b0;
                  end else if (!byte_in[0]) begin
                    kind <= BK_CMD;
                  end else begin
                    go_tx <= 1'b1;
                    if (blk_mode || !have_cmd) begin
                      ptr        <= '0;
                      send_count <= 1'b1;
                    end else begin
                      ptr        <= {1'b0, cmd_off};
                      send_count <= 1'b0;
                    end
                  end
                end
                BK_CMD: begin
                  blk_mode <= ~byte_in[7];
                  cmd_off  <= byte_in[6:0];
                  have_cmd <= 1'b1;
                  ptr      <= byte_in[7] ? {1'b0, byte_in[6:0]} : 8'd0;
                  kind     <= byte_in[7] ? BK_DATA : BK_CNT;
                end
                BK_CNT: kind <= BK_DATA;
                default: begin
                  if (in_range) begin
                    push      <= 1'b1;
                    push_addr <= ptr[AW-1:0];
                    push_data <= byte_in;
                  end
                  ptr <= ptr_nxt;
                end
              endcase
            end else begin
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
          ST_ACK_SET: if (scl_fall) begin
            if (ack_en) begin
              oe_q  <= 1'b1;
              state <= ST_ACK;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_ACK: if (scl_fall) begin
            bit_cnt <= '0;
            if (go_tx) begin
              tx_q  <= tx_byte[6:0];
              oe_q  <= ~tx_byte[7];
              state <= ST_TX;
            end else begin
              oe_q  <= 1'b0;
              state <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
            if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                oe_q  <= 1'b0;
                state <= ST_MACK;
              end else begin
                oe_q <= ~tx_q[6];
                tx_q <= {tx_q[5:0], 1'b0};
              end
            end
          end
          ST_MACK: if (scl_rise) begin
            if (sda_i) begin
              state <= ST_IGNORE;
            end else begin
              state <= ST_LOAD;
              if (send_count) send_count <= 1'b0;
              else            ptr        <= ptr_nxt;
            end
          end
          ST_LOAD: if (scl_fall) begin
            tx_q    <= tx_byte[6:0];
            oe_q    <= ~tx_byte[7];
            bit_cnt <= '0;
            state   <= ST_TX;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_i,
  input logic          sda_oe,
  input logic          reg_wr_valid,
  input logic          reg_wr_ready,
  input logic [AW-1:0] reg_wr_addr,
  input logic [7:0]    reg_wr_data
);
  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_valid && !reg_wr_ready) |=> (reg_wr_valid && $stable(reg_wr_addr) && $stable(reg_wr_data))); // R12

  AST_OE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !$stable(sda_oe)) |-> !sda_oe); // R13

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_oe); // R9

  AST_WR_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_wr_valid) |-> scl_i); // R8
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
  .reg_wr_valid(reg_wr_valid), .reg_wr_ready(reg_wr_ready),
  .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data)
);

// File: tb/test_smb_cfg_slave.sv
module test_smb_cfg_slave;
  localparam int NREG = 8;
  localparam int AW   = 3;
  localparam int HALF = 6;

  typedef struct packed { logic [AW-1:0] a; logic [7:0] d; } wr_item_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, bp_en = 1'b0;
  logic sda_oe, wr_valid, wr_ready, sda_bus;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [7:0] bank [NREG];
  logic [7:0] model [NREG];
  wr_item_t expq[$];
  int checks = 0, errors = 0, cyc = 0;
  logic done = 1'b0;

  assign sda_bus  = sda_m & ~sda_oe;
  assign wr_ready = bp_en ? (cyc[1:0] == 2'b11) : 1'b1;
  assign rd_data  = bank[rd_addr];

  smb_cfg_slave i_smb_cfg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_wr_valid(wr_valid), .reg_wr_ready(wr_ready), .reg_wr_addr(wr_addr),
    .reg_wr_data(wr_data), .reg_rd_addr(rd_addr), .reg_rd_data(rd_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= 8'h10 + 8'(i);
    end else if (wr_valid && wr_ready) begin
      bank[wr_addr] <= wr_data;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every write handshake must match the queue head
  always @(negedge clk) begin
    wr_item_t it;
    if (rst_n && wr_valid && wr_ready) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected write actual=%0d:%h expected=none", wr_addr, wr_data);
      end else begin
        it = expq.pop_front();
        if (it.a !== wr_addr || it.d !== wr_data) begin
          errors++;
          $display("FAIL R12 write actual=%0d:%h expected=%0d:%h", wr_addr, wr_data, it.a, it.d);
        end
      end
    end
  end

  // R13: any sda_oe change must follow SCL low (or be a release)
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev) begin
      chk("R13 oe change while SCL high", {31'b0, scl_m & sda_oe}, 32'd0);
    end
    oe_prev <= sda_oe;
  end

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic seen);
    sda_m = b;
    hold(HALF);
    scl_m = 1'b1;
    hold(HALF / 2);
    seen = sda_bus;
    hold(HALF - HALF / 2);
    scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(HALF);
    scl_m = 1'b1; hold(HALF);
    sda_m = 1'b0; hold(HALF);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(HALF);
    scl_m = 1'b1; hold(HALF);
    sda_m = 1'b1; hold(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    chk(req, {31'b0, ~s}, {31'b0, exp_ack});
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      b[i] = s;
    end
    bit_io(~ack, s);
  endtask

  task automatic expect_wr(input int a, input logic [7:0] d);
    expq.push_back('{a: AW'(a), d: d});
    model[a] = d;
  endtask

  task automatic drain(string req);
    hold(40);
    chk(req, expq.size(), 0);
  endtask

  initial begin
    logic [7:0] rb;
    logic s;
    for (int i = 0; i < NREG; i++) model[i] = 8'h10 + 8'(i);
    hold(3);
    chk("R13 reset oe", {31'b0, sda_oe}, 0);
    chk("R12 reset valid", {31'b0, wr_valid}, 0);
    rst_n = 1'b1;
    hold(4);

    // R3 single-byte write at offset 3
    bus_start();
    send_byte(8'hD2, 1'b1, "R1 write address ack");
    send_byte(8'h83, 1'b1, "R3 command ack");
    expect_wr(3, 8'h5A);
    send_byte(8'h5A, 1'b1, "R3 data ack");
    bus_stop();
    drain("R3 write issued");

    // R6 R7 single-byte read back
    bus_start();
    send_byte(8'hD2, 1'b1, "R1 address ack");
    send_byte(8'h83, 1'b1, "R6 command ack");
    bus_start();
    send_byte(8'hD3, 1'b1, "R1 read address ack");
    recv_byte(1'b0, rb);
    chk("R6 R7 read offset 3", rb, model[3]);
    chk("R9 released after NACK", {31'b0, sda_oe}, 0);
    recv_byte(1'b0, rb);
    chk("R9 silent after NACK", rb, 8'hFF);
    bus_stop();

    // R6 out-of-range read offset 10
    bus_start();
    send_byte(8'hD2, 1'b1, "R1 address ack");
    send_byte(8'h8A, 1'b1, "R6 command ack");
    bus_start();
    send_byte(8'hD3, 1'b1, "R1 read address ack");
    recv_byte(1'b0, rb);
    chk("R6 offset past range", rb, 8'hFF);
    bus_stop();

    // R2 foreign address, later bytes ignored
    bus_start();
    send_byte(8'hA4, 1'b0, "R2 foreign address nack");
    send_byte(8'h83, 1'b0, "R2 ignored byte");
    send_byte(8'h99, 1'b0, "R2 ignored byte");
    bus_stop();
    drain("R2 no write");

    // R4 R8 R12 block write, stop inside 4th byte, bank stalls
    bp_en = 1'b1;
    bus_start();
    send_byte(8'hD2, 1'b1, "R1 address ack");
    send_byte(8'h00, 1'b1, "R4 command ack");
    send_byte(8'h08, 1'b1, "R4 count ack");
    expect_wr(0, 8'h11); send_byte(8'h11, 1'b1, "R4 data ack");
    expect_wr(1, 8'h22); send_byte(8'h22, 1'b1, "R4 data ack");
    expect_wr(2, 8'h33); send_byte(8'h33, 1'b1, "R4 data ack");
    for (int i = 0; i < 4; i++) bit_io(1'b0, s);
    bus_stop();
    drain("R8 partial byte dropped");
    bp_en = 1'b0;

    // R10 writes past the last register are acked, not written
    bus_start();
    send_byte(8'hD2, 1'b1, "R1 address ack");
    send_byte(8'h86, 1'b1, "R3 command ack");
    expect_wr(6, 8'h66); send_byte(8'h66, 1'b1, "R3 data ack");
    expect_wr(7, 8'h77); send_byte(8'h77, 1'b1, "R3 data ack");
    send_byte(8'h88, 1'b1, "R10 out-of-range ack");
    bus_stop();
    drain("R10 no write past range");

    // R5 block read: count, all registers, filler
    bus_start();
    send_byte(8'hD2, 1'b1, "R1 address ack");
    send_byte(8'h00, 1'b1, "R5 command ack");
    bus_start();
    send_byte(8'hD3, 1'b1, "R1 read address ack");
    recv_byte(1'b1, rb);
    chk("R5 byte count", rb, NREG);
    for (int i = 0; i < NREG; i++) begin
      recv_byte(1'b1, rb);
      chk($sformatf("R5 R7 block data %0d", i), rb, model[i]);
    end
    recv_byte(1'b0, rb);
    chk("R5 filler past range", rb, 8'hFF);
    bus_stop();

    // R11 start inside a byte restarts address phase
    bus_start();
    for (int i = 0; i < 4; i++) bit_io(i[0], s);
    bus_start();
    send_byte(8'hD2, 1'b1, "R11 address after restart");
    send_byte(8'h81, 1'b1, "R11 command ack");
    expect_wr(1, 8'hC3); send_byte(8'hC3, 1'b1, "R11 data ack");
    bus_stop();
    drain("R11 write after restart");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule